// File: doc/BRIEF.md
# Spaced Two-Word Transmit Sequencer

This block hands two 16-bit words, one at a time, to a serial transmitter that sits after it. A trigger starts a burst. The block then raises a busy flag and runs an internal delay counter of 2^GAP_W states. Each time that counter rolls over, the block sends a single-cycle start pulse to the transmitter and moves to the next word slot. The slot decides what appears on the data bus. In slot 1 the bus carries the first word, in slot 2 it carries the second word, and in every other slot it carries zeros.

A burst ends after the third rollover. On that pulse the data bus reads zero. Busy drops on the following clock. Every register is updated on the rising edge of the single clock. The only other input that acts on the registers is the asynchronous active-low reset.

Top module: `serial_word_sequencer`

## Requirements
- R1: While reset is low, busy, tx_start and every bit of tx_data are 0. The same values hold on the first cycle after reset is released.
- R2: When busy is low and trig is high at a rising edge, busy is 1 after that edge, and the delay counter and slot both restart from 0.
- R3: tx_start is high for exactly one cycle at a time. The first pulse starts 512 rising edges after the trigger edge (2^GAP_W with the default GAP_W = 9), and each later pulse starts 512 edges after the one before it.
- R4: While the slot is 1, which covers the first pulse, tx_data equals word_a. While the slot is 2, which covers the second pulse, tx_data equals word_b.
- R5: In every other slot tx_data is all zeros. This includes the wait before the first pulse, the third pulse, and the whole time the block is idle.
- R6: A burst gives exactly three pulses. busy goes low on the rising edge that follows the end of the third pulse.
- R7: A trigger that arrives while busy is high has no effect on pulse timing or on the data shown. If trig is held high, a new burst starts on the first edge at which busy is already low.
- R8: tx_data follows word_a and word_b combinationally within the active slot, so a change to an input during its slot appears on the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; only rising edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Starts a burst when sampled high while idle |
| word_a | input | WORD_W | Word presented in slot 1 |
| word_b | input | WORD_W | Word presented in slot 2 |
| tx_data | output | WORD_W | Word offered to the transmitter |
| tx_start | output | 1 | One-cycle start pulse to the transmitter |
| busy | output | 1 | High for the duration of a burst |

## Verification
If the delay counter rolls over at the wrong value, the first start pulse lands at the wrong distance from the trigger. The error is visible at the ports within one spacing period of 512 cycles. If the slot register gets out of step, the wrong word, or a non-zero value, is on the bus in the same cycle as a pulse. A busy flag that clears too early or too late changes the number of pulses in a burst, and this appears at the end of the burst. A block that restarts on a trigger during a burst shifts the next pulse away from its 512-cycle mark.

// File: rtl/serial_word_sequencer.sv
module serial_word_sequencer #(
  parameter int WORD_W = 16,
  parameter int GAP_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_start,
  output logic              busy
);

  localparam logic [GAP_W-1:0] GAP_LAST = '1;
  localparam logic [1:0]       SLOT_A   = 2'd1;
  localparam logic [1:0]       SLOT_B   = 2'd2;
  localparam logic [1:0]       SLOT_END = 2'd3;

  logic [GAP_W-1:0] gap_q;
  logic [1:0]       slot_q;

  wire rollover = (gap_q == GAP_LAST);
  wire finished = (slot_q == SLOT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      gap_q    <= '0;
      slot_q   <= '0;
      tx_start <= 1'b0;
    end else if (busy) begin
      if (finished) begin
        busy     <= 1'b0;
        gap_q    <= '0;
        tx_start <= 1'b0;
      end else if (rollover) begin
        gap_q    <= '0;
        slot_q   <= slot_q + 2'd1;
        tx_start <= 1'b1;
      end else begin
        gap_q    <= gap_q + 1'b1;
        tx_start <= 1'b0;
      end
    end else begin
      tx_start <= 1'b0;
      if (trig) begin
        busy   <= 1'b1;
        gap_q  <= '0;
        slot_q <= '0;
      end
    end
  end

  assign tx_data = (slot_q == SLOT_A) ? word_a :
                   (slot_q == SLOT_B) ? word_b : '0;

endmodule

// File: rtl/serial_word_sequencer_chk.sv
module serial_word_sequencer_chk #(
  parameter int WORD_W = 16,
  parameter int GAP_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic [WORD_W-1:0] word_a,
  input logic [WORD_W-1:0] word_b,
  input logic [WORD_W-1:0] tx_data,
  input logic              tx_start,
  input logic              busy
);

  localparam int PERIOD = 1 << GAP_W;

  logic [GAP_W+1:0] since_q;
  logic [1:0]       pulses_q;
  wire accept = !busy && trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q  <= '0;
      pulses_q <= '0;
    end else if (accept) begin
      since_q  <= '0;
      pulses_q <= '0;
    end else if (tx_start) begin
      since_q  <= 1;
      pulses_q <= pulses_q + 2'd1;
    end else if (since_q != '1) begin
      since_q  <= since_q + 1'b1;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tx_start |=> !tx_start); // R3
  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n) tx_start |-> (since_q == PERIOD)); // R3
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R2
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n) (tx_start && pulses_q == 2'd0) |-> (tx_data == word_a)); // R4
  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n) (tx_start && pulses_q == 2'd1) |-> (tx_data == word_b)); // R4
  AST_THIRD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tx_start && pulses_q == 2'd2) |-> (tx_data == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (tx_data == '0)); // R5
  AST_START_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) tx_start |-> busy); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ($past(tx_start) && pulses_q == 2'd3)); // R6

endmodule

bind serial_word_sequencer serial_word_sequencer_chk #(.WORD_W(WORD_W), .GAP_W(GAP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .word_a(word_a), .word_b(word_b),
  .tx_data(tx_data), .tx_start(tx_start), .busy(busy)
);

// File: tb/test_serial_word_sequencer.sv
module test_serial_word_sequencer;
  localparam int WORD_W = 16;
  localparam int GAP_W  = 9;
  localparam int PERIOD = 1 << GAP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [WORD_W-1:0] word_a = '0;
  logic [WORD_W-1:0] word_b = '0;
  logic [WORD_W-1:0] tx_data;
  logic tx_start, busy;

  serial_word_sequencer #(.WORD_W(WORD_W), .GAP_W(GAP_W)) i_serial_word_sequencer (
    .clk(clk), .rst_n(rst_n), .trig(trig), .word_a(word_a), .word_b(word_b),
    .tx_data(tx_data), .tx_start(tx_start), .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  int m_busy = 0, m_cnt = 0, m_slot = 0, m_start = 0;
  int last_edge = 0, pulse_no = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_slot = 0; m_start = 0; pulse_no = 0;
    end else begin
      cyc++;
      if (m_busy != 0) begin
        if (m_slot == 3) begin
          m_busy = 0; m_cnt = 0; m_start = 0;
        end else if (m_cnt == PERIOD - 1) begin
          m_cnt = 0; m_start = 1; m_slot++;
        end else begin
          m_cnt++; m_start = 0;
        end
      end else begin
        m_start = 0;
        if (trig) begin
          m_busy = 1; m_cnt = 0; m_slot = 0; last_edge = cyc; pulse_no = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [WORD_W-1:0] exp_data;
      exp_data = (m_slot == 1) ? word_a : (m_slot == 2) ? word_b : '0;
      chk("R2/R6", "busy", busy, m_busy);
      chk("R3", "tx_start", tx_start, m_start);
      chk((m_slot == 1 || m_slot == 2) ? "R4/R8" : "R5", "tx_data", tx_data, exp_data);
      if (rst_n && tx_start) begin
        pulse_no++;
        chk("R3", "pulse spacing", cyc - last_edge, PERIOD);
        last_edge = cyc;
        if (pulse_no == 1) chk("R4", "word at pulse 1", tx_data, word_a);
        else if (pulse_no == 2) chk("R4", "word at pulse 2", tx_data, word_b);
        else chk("R5", "word at pulse 3", tx_data, 0);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    // R1: outputs held at zero during reset
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "tx_start in reset", tx_start, 0);
    chk("R1", "tx_data in reset", tx_data, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "busy after reset", busy, 0);

    // burst 1: single-cycle trigger
    word_a = 16'h1234; word_b = 16'hBEEF;
    trig = 1'b1; step(1); trig = 1'b0;
    chk("R2", "busy after trigger", busy, 1);
    step(3 * PERIOD + 20);
    chk("R6", "idle after burst", busy, 0);

    // burst 2: R7 trigger again mid-burst, R8 word changes inside its slot
    word_a = 16'h00FF; word_b = 16'h8001;
    trig = 1'b1; step(1); trig = 1'b0;
    step(300);
    trig = 1'b1; step(2); trig = 1'b0;
    step(PERIOD);
    word_a = 16'hA5A5;
    step(PERIOD);
    word_b = 16'h5A5A;
    step(PERIOD + 20);
    chk("R7", "idle after burst with extra trigger", busy, 0);

    // R7: trigger held high restarts right after a burst ends
    word_a = 16'hFFFF; word_b = 16'h0000;
    trig = 1'b1;
    step(3 * PERIOD + 10);
    chk("R7", "busy with trigger held", busy, 1);
    trig = 1'b0;
    step(3 * PERIOD + 20);
    chk("R6", "idle after held-trigger bursts", busy, 0);

    // R1: reset in the middle of a burst
    word_a = 16'hC3C3; word_b = 16'h3C3C;
    trig = 1'b1; step(1); trig = 1'b0;
    step(PERIOD + 100);
    rst_n = 1'b0;
    step(2);
    chk("R1", "tx_data after mid-burst reset", tx_data, 0);
    rst_n = 1'b1;
    step(PERIOD + 10);
    chk("R1", "stays idle after reset", busy, 0);

    // short final burst
    word_a = 16'h0001; word_b = 16'h8000;
    trig = 1'b1; step(1); trig = 1'b0;
    step(3 * PERIOD + 20);
    chk("R6", "idle at end", busy, 0);
    finish_run();
  end
endmodule